// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of an SDRAM interface (chip select, row strobe, column strobe, write enable and clock enable), along with the bank-select and address lines. On every rising clock edge it turns them into a single decoded command. For each bank it records whether the bank is idle or holds an open row, and which row that is. It is meant to sit beside a memory controller or a memory model as a protocol monitor and state tracker.

The block catches the command sequences the protocol forbids and raises an error strobe with a cause code when it sees one. These are:
- activating a second row in a bank that is already open,
- accessing a bank that is idle,
- refreshing while any bank is open,
- loading the mode register while any bank is open,
- issuing any executable command inside the mode-register settle window.

A rejected command changes nothing. Accesses that ask for auto-precharge close their bank after a set number of clocks. Every result is registered, so it appears on the outputs just after the edge that sampled the command.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A command is sampled on each rising edge and its code shows on `cmdCode` after that edge. The codes are: chip select high = 0 (inhibit). Otherwise, `{rasN,casN,weN}` selects the code: 111 = 1 (NOP), 011 = 2 (ACTIVE), 101 = 3 (READ), 100 = 4 (WRITE), 110 = 5 (burst stop), 010 = 6 (PRECHARGE), 001 = 7 (auto refresh) or 8 (self refresh), and 000 = 9 (mode load).
- R2: With chip select high, the pin pattern on the other lines has no effect on bank state, and it raises no error. An auto-precharge countdown that is already running keeps running.
- R3: ACTIVE to an idle bank sets that bank's bit in `bankOpen` and stores the address as its row in `openRows`. Bank b's row sits at `openRows[b*ADDR_W +: ADDR_W]`.
- R4: ACTIVE to an open bank with a different row raises error cause 1 and leaves the stored row unchanged. ACTIVE with the same row is ignored and raises no error.
- R5: READ or WRITE to an idle bank raises error cause 2 and leaves every bank unchanged.
- R6: READ or WRITE to an open bank with address bit 10 high closes that bank BURST_LEN edges after the command. With bit 10 low, the bank stays open.
- R7: PRECHARGE with address bit 10 low closes only the bank on `ba`. With bit 10 high, it closes every bank whatever `ba` holds.
- R8: Refresh decodes as code 7 with `cke` high and as code 8 with `cke` low. If any bank is open, refresh raises error cause 3.
- R9: A mode load while all banks are idle copies the address into `modeWord`. While any bank is open, it raises error cause 4 and leaves `modeWord` unchanged.
- R10: After an accepted mode load, any command other than NOP or inhibit on the next TMRD-1 edges raises error cause 5 and has no effect. The edge TMRD cycles after the load accepts commands again.
- R11: After reset, `cmdCode` is 0, no bank is open, all rows and `modeWord` are 0, and `errStb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; picks auto or self refresh |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (12) | Row, column/control or op-code |
| cmdCode | output | 4 | Decoded command code |
| bankOpen | output | NUM_BANKS (4) | One bit per bank, high when a row is open |
| openRows | output | NUM_BANKS*ADDR_W (48) | Open row of each bank, bank 0 in the low bits |
| modeWord | output | ADDR_W (12) | Last accepted mode op-code |
| errStb | output | 1 | High for one cycle after an illegal command |
| errCause | output | 3 | Error cause: 0 none, 1 row conflict, 2 idle access, 3 refresh while open, 4 mode load while open, 5 settle lockout |

## Verification
Apart from one case, every result of a command is due right after the rising edge that samples it: the decoded code, the error strobe and cause, bank state, the row and the mode word. The bench therefore drives pins at a falling edge and checks the outputs at the next falling edge. Auto-precharge closure is due BURST_LEN edges after the access. The bench steps through those edges one at a time, confirms the bank is still open on the edge before the closing one, and confirms it is closed on the closing edge itself. The settle lockout covers the TMRD-1 edges after a mode load; the bench checks a blocked command inside that window and an accepted one on the first edge after it.

// File: rtl/sdct_pkg.sv
package sdct_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACTIVE  = 4'd2,
    CMD_READ    = 4'd3,
    CMD_WRITE   = 4'd4,
    CMD_BSTOP   = 4'd5,
    CMD_PRECH   = 4'd6,
    CMD_AREF    = 4'd7,
    CMD_SREF    = 4'd8,
    CMD_MODE    = 4'd9
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ROW      = 3'd1,
    ERR_IDLE     = 3'd2,
    ERR_REFOPEN  = 3'd3,
    ERR_MODEBUSY = 3'd4,
    ERR_MRD      = 3'd5
  } err_e;

  // Strobes from control to the bank datapath (one cycle, combinational)
  typedef struct packed {
    logic openStb;   // open row in selected bank
    logic accessStb; // read/write to selected open bank
    logic apReq;     // access asks for auto-precharge
    logic closeOne;  // precharge selected bank
    logic closeAll;  // precharge every bank
    logic modeLoad;  // capture op-code
  } strobe_t;

endpackage

// File: rtl/sdct_ctrl.sv
module sdct_ctrl
  import sdct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int TMRD      = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          rasN,
  input  logic                          casN,
  input  logic                          weN,
  input  logic                          cke,
  input  logic [BA_W-1:0]               ba,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_BANKS-1:0]          bankOpen,
  input  logic [NUM_BANKS*ADDR_W-1:0]   openRows,
  output strobe_t                       strb,
  output logic [3:0]                    cmdCode,
  output logic                          errStb,
  output logic [2:0]                    errCause
);

  localparam int MRD_W = (TMRD > 1) ? $clog2(TMRD) : 1;

  logic [2:0]        pins;
  cmd_e              decCmd;
  err_e              cause;
  logic [MRD_W-1:0]  mrdCnt;
  logic              lockOn;
  logic              selOpen;
  logic [ADDR_W-1:0] selRow;

  assign pins    = {rasN, casN, weN};
  assign lockOn  = (mrdCnt != '0);
  assign selOpen = bankOpen[ba];
  assign selRow  = openRows[ba*ADDR_W +: ADDR_W];

  always_comb begin
    if (csN) decCmd = CMD_INHIBIT;
    else begin
      case (pins)
        3'b111:  decCmd = CMD_NOP;
        3'b011:  decCmd = CMD_ACTIVE;
        3'b101:  decCmd = CMD_READ;
        3'b100:  decCmd = CMD_WRITE;
        3'b110:  decCmd = CMD_BSTOP;
        3'b010:  decCmd = CMD_PRECH;
        3'b001:  decCmd = cke ? CMD_AREF : CMD_SREF;
        default: decCmd = CMD_MODE;
      endcase
    end
  end

  always_comb begin
    cause = ERR_NONE;
    strb  = '0;
    if (lockOn && decCmd != CMD_INHIBIT && decCmd != CMD_NOP) begin
      cause = ERR_MRD;
    end else begin
      case (decCmd)
        CMD_ACTIVE: begin
          if (!selOpen)              strb.openStb = 1'b1;
          else if (selRow != addr)   cause = ERR_ROW;
        end
        CMD_READ, CMD_WRITE: begin
          if (!selOpen) cause = ERR_IDLE;
          else begin
            strb.accessStb = 1'b1;
            strb.apReq     = addr[AP_BIT];
          end
        end
        CMD_PRECH: begin
          if (addr[AP_BIT]) strb.closeAll = 1'b1;
          else              strb.closeOne = 1'b1;
        end
        CMD_AREF, CMD_SREF: begin
          if (|bankOpen) cause = ERR_REFOPEN;
        end
        CMD_MODE: begin
          if (|bankOpen) cause = ERR_MODEBUSY;
          else           strb.modeLoad = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode  <= 4'(CMD_INHIBIT);
      errStb   <= 1'b0;
      errCause <= 3'(ERR_NONE);
      mrdCnt   <= '0;
    end else begin
      cmdCode  <= 4'(decCmd);
      errStb   <= (cause != ERR_NONE);
      errCause <= 3'(cause);
      if (strb.modeLoad)  mrdCnt <= MRD_W'(TMRD - 1);
      else if (lockOn)    mrdCnt <= mrdCnt - 1'b1;
    end
  end

  // R10
  mrd_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockOn && !csN && pins != 3'b111) |=> (errStb && errCause == 3'(ERR_MRD)));

  // R9
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeLoad |-> (bankOpen == '0));

  // R8
  refresh_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lockOn && !csN && pins == 3'b001 && |bankOpen) |=> (errCause == 3'(ERR_REFOPEN)));

  // R2
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (cmdCode == 4'(CMD_INHIBIT) && !errStb));

endmodule

// File: rtl/sdct_bank.sv
module sdct_bank
  import sdct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 12,
  parameter int BURST_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [BA_W-1:0]             ba,
  input  logic [ADDR_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]        bankOpen,
  output logic [NUM_BANKS*ADDR_W-1:0] openRows,
  output logic [ADDR_W-1:0]           modeWord
);

  localparam int CNT_W = $clog2(BURST_LEN + 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              hit;
    logic              openQ;
    logic [ADDR_W-1:0] rowQ;
    logic [CNT_W-1:0]  apCnt;

    assign hit = (ba == BA_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
        apCnt <= '0;
      end else if (strb.closeAll || (strb.closeOne && hit)) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (strb.openStb && hit) begin
        openQ <= 1'b1;
        rowQ  <= addr;
      end else if (strb.accessStb && hit) begin
        apCnt <= strb.apReq ? CNT_W'(BURST_LEN) : '0;
      end else if (apCnt == CNT_W'(1)) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (apCnt != '0) begin
        apCnt <= apCnt - 1'b1;
      end
    end

    assign bankOpen[g]                    = openQ;
    assign openRows[g*ADDR_W +: ADDR_W]   = rowQ;

    // R6
    ap_pending_open_chk: assert property (@(posedge clk) disable iff (!rstN)
      (apCnt != '0) |-> openQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeWord <= '0;
    else if (strb.modeLoad) modeWord <= addr;
  end

  // R7
  close_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.closeAll |=> (bankOpen == '0));

  // R4
  open_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.openStb |-> !bankOpen[ba]);

  // R5
  access_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accessStb |-> bankOpen[ba]);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int TMRD      = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        csN,
  input  logic                        rasN,
  input  logic                        casN,
  input  logic                        weN,
  input  logic                        cke,
  input  logic [BA_W-1:0]             ba,
  input  logic [ADDR_W-1:0]           addr,
  output logic [3:0]                  cmdCode,
  output logic [NUM_BANKS-1:0]        bankOpen,
  output logic [NUM_BANKS*ADDR_W-1:0] openRows,
  output logic [ADDR_W-1:0]           modeWord,
  output logic                        errStb,
  output logic [2:0]                  errCause
);

  strobe_t strb;

  sdct_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT), .TMRD(TMRD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .cke(cke), .ba(ba), .addr(addr),
    .bankOpen(bankOpen), .openRows(openRows), .strb(strb),
    .cmdCode(cmdCode), .errStb(errStb), .errCause(errCause)
  );

  sdct_bank #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ADDR_W(ADDR_W),
    .BURST_LEN(BURST_LEN)
  ) bank_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ba(ba), .addr(addr),
    .bankOpen(bankOpen), .openRows(openRows), .modeWord(modeWord)
  );

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmdCode;
  logic [3:0]  bankOpen;
  logic [47:0] openRows;
  logic [11:0] modeWord;
  logic        errStb;
  logic [2:0]  errCause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .ba(ba), .addr(addr), .cmdCode(cmdCode), .bankOpen(bankOpen),
    .openRows(openRows), .modeWord(modeWord), .errStb(errStb), .errCause(errCause)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one command at a falling edge; return at the next falling edge.
  task automatic send(logic c, logic [2:0] p, logic [1:0] b, logic [11:0] a);
    csN = c; {rasN, casN, weN} = p; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();      send(1'b0, 3'b111, 2'd0, 12'h000); endtask
  task automatic act(logic [1:0] b, logic [11:0] r); send(1'b0, 3'b011, b, r); endtask
  task automatic prechAll(); send(1'b0, 3'b010, 2'd0, 12'h400); endtask

  function automatic int rowOf(int b);
    return int'(openRows[b*12 +: 12]);
  endfunction

  task automatic t_reset();
    check("R11 cmd", cmdCode, 0);
    check("R11 open", bankOpen, 0);
    check("R11 rows", (openRows == '0) ? 1 : 0, 1);
    check("R11 mode", modeWord, 0);
    check("R11 err", errStb, 0);
  endtask

  task automatic t_decode();
    nop();                              check("R1 nop", cmdCode, 1);
    send(1'b0, 3'b110, 2'd0, 12'h0);    check("R1 bstop", cmdCode, 5);
    act(2'd0, 12'h123);                 check("R1 active", cmdCode, 2);
    check("R3 open", bankOpen, 4'b0001);
    check("R3 row", rowOf(0), 12'h123);
    send(1'b0, 3'b101, 2'd0, 12'h005); check("R1 read", cmdCode, 3);
    check("R1 read err", errStb, 0);
    send(1'b0, 3'b100, 2'd0, 12'h006); check("R1 write", cmdCode, 4);
    send(1'b1, 3'b010, 2'd0, 12'h000); check("R2 inhibit code", cmdCode, 0);
    check("R2 inhibit state", bankOpen, 4'b0001);
    check("R2 inhibit err", errStb, 0);
    send(1'b0, 3'b010, 2'd0, 12'h000); check("R1 prech", cmdCode, 6);
    check("R7 single close", bankOpen, 0);
  endtask

  task automatic t_row();
    act(2'd1, 12'h055);
    act(2'd1, 12'h0AA);  check("R4 conflict err", errStb, 1);
    check("R4 conflict cause", errCause, 1);
    check("R4 row kept", rowOf(1), 12'h055);
    act(2'd1, 12'h055);  check("R4 same row no err", errStb, 0);
    send(1'b0, 3'b010, 2'd1, 12'h000);
    act(2'd1, 12'h0AA);  check("R4 after prech", rowOf(1), 12'h0AA);
    check("R4 after prech err", errStb, 0);
    prechAll();
  endtask

  task automatic t_idle();
    send(1'b0, 3'b101, 2'd2, 12'h0);  check("R5 read idle", errCause, 2);
    check("R5 state", bankOpen, 0);
    send(1'b0, 3'b100, 2'd3, 12'h0);  check("R5 write idle", errCause, 2);
    check("R5 write state", bankOpen, 0);
  endtask

  task automatic t_autopre();
    act(2'd2, 12'h003);
    send(1'b0, 3'b101, 2'd2, 12'h400);  // edge k
    check("R6 err", errStb, 0);
    nop();                              // k+1
    send(1'b1, 3'b000, 2'd2, 12'h000);  // k+2 inhibit, countdown continues
    nop();                              // k+3
    check("R6 still open", bankOpen, 4'b0100);
    nop();                              // k+4
    check("R6 closed", bankOpen, 0);
    check("R2 countdown ran", bankOpen[2], 0);
    act(2'd2, 12'h004);
    send(1'b0, 3'b100, 2'd2, 12'h000);
    for (int i = 0; i < 6; i++) nop();
    check("R6 no ap stays open", bankOpen, 4'b0100);
    prechAll();
  endtask

  task automatic t_prech();
    act(2'd0, 12'h1); act(2'd1, 12'h2); act(2'd3, 12'h3);
    check("R3 three open", bankOpen, 4'b1011);
    send(1'b0, 3'b010, 2'd2, 12'h400); check("R7 all closed", bankOpen, 0);
    act(2'd0, 12'h1); act(2'd1, 12'h2);
    send(1'b0, 3'b010, 2'd1, 12'h000); check("R7 one closed", bankOpen, 4'b0001);
    prechAll();
  endtask

  task automatic t_refresh();
    cke = 1'b1; send(1'b0, 3'b001, 2'd0, 12'h0);
    check("R8 auto", cmdCode, 7);  check("R8 auto err", errStb, 0);
    cke = 1'b0; send(1'b0, 3'b001, 2'd0, 12'h0);
    check("R8 self", cmdCode, 8);
    cke = 1'b1;
    act(2'd0, 12'h7);
    send(1'b0, 3'b001, 2'd0, 12'h0);
    check("R8 open err", errCause, 3);
    prechAll();
  endtask

  task automatic t_mode();
    act(2'd3, 12'h9);
    send(1'b0, 3'b000, 2'd0, 12'h237); check("R9 busy", errCause, 4);
    check("R9 word kept", modeWord, 0);
    prechAll();
    send(1'b0, 3'b000, 2'd0, 12'h237); check("R1 mode", cmdCode, 9);
    check("R9 word", modeWord, 12'h237);
    check("R9 err", errStb, 0);
    act(2'd0, 12'h11); check("R10 locked", errCause, 5);
    check("R10 no effect", bankOpen, 0);
    act(2'd0, 12'h11); check("R10 released", bankOpen, 4'b0001);
    check("R10 released err", errStb, 0);
    prechAll();
    send(1'b0, 3'b000, 2'd0, 12'h015);
    nop(); check("R10 nop allowed", errStb, 0);
    act(2'd1, 12'h22); check("R10 after nop", bankOpen, 4'b0010);
    prechAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_decode();
    t_row();
    t_idle();
    t_autopre();
    t_prech();
    t_refresh();
    t_mode();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule